// File: doc/BRIEF.md
# Multi-Lane Serial Frame Shifter

This block moves 1- to 8-bit frames between a small register interface and a serial bus that has one, two or four data lanes. Software pushes outgoing frames into a transmit queue and pops incoming frames from a receive queue. A separate clock and chip-select sequencer supplies launch and sample strobes. Each sample strobe captures one beat, and each launch strobe presents the next one. A format register sets the lane count, the bit order, the frame length and whether a frame is transmit-only. The format is latched when a frame is loaded from the transmit queue.

Each queue has a programmable watermark. The watermark comparisons drive two pending bits, and these are masked by an enable register to form a single interrupt. Full and empty status is returned in bit 31 of the data registers, so polling software needs only one read per entry.

Top module: `spi_lane_shifter`

## Requirements
- R1: After reset the format register reads 0x0008_0000, the pending register reads 0, irq is low, frame_active is low and dq_oe is 0.
- R2: Format bits [1:0] select the lanes: 0 means one lane, 1 means two lanes, 2 means four lanes, and the reserved 3 behaves as one lane. With one lane the block drives dq_out[0] with dq_oe = 0001 and samples dq_in[1]. With two or four lanes it drives and samples dq[W-1:0], and dq_oe is all W lanes for a transmit-only frame and 0 otherwise.
- R3: Format bit 2 set sends and assembles the frame least-significant bit first, with lane 0 carrying the lowest bit of each beat. Clear sends it most-significant bit first, with the highest lane carrying the highest bit of each beat.
- R4: Format [19:16] gives the frame length L. A value of 0, or a value above 8, means 8. A frame takes ceil(L/W) sample strobes, and the unused positions of the final beat are padding.
- R5: Format bit 3 set marks the frame transmit-only, and the frame pushes nothing into the receive queue.
- R6: Reading the TX data register (select 1) returns bit 31 set exactly when the 8-entry transmit queue is full. A write to it while the queue is full is dropped.
- R7: Reading the RX data register (select 2) pops the oldest entry into bits [7:0] with bit 31 clear. When the queue is empty the read returns 0x8000_0000 and leaves the queue unchanged.
- R8: Pending register (select 6) bit 0 is high while the transmit count is below the TX mark (select 3). Bit 1 is high while the receive count is above the RX mark (select 4). Both bits follow the counts level by level.
- R9: irq is high exactly when some pending bit is high and its bit in the enable register (select 5) is set.
- R10: The block loads a frame as soon as it is idle and the transmit queue is not empty, and it loads entries in the order they were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_sel | input | 3 | Register select |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe; pops RX data when select is 2 |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the selected register |
| sck_launch | input | 1 | Present the next beat |
| sck_sample | input | 1 | Capture the current beat |
| dq_in | input | 4 | Serial lane inputs |
| dq_out | output | 4 | Serial lane outputs |
| dq_oe | output | 4 | Per-lane output enables |
| frame_active | output | 1 | A frame is in progress |
| irq | output | 1 | Masked watermark interrupt |

## Verification
A table of frames covers each lane count, both bit orders, full-duplex and transmit-only frames, and lengths of 3, 5, 6, 7, 8, 0 and 12. The short lengths with two or four lanes show whether padding in the final beat is dropped on the correct side for each bit order. Distinct asymmetric bytes on transmit and receive expose lane swaps and reversed order. Directed runs overfill the transmit queue, underflow the receive queue and sweep the watermarks across the live count. These runs separate a dropped write from a corrupted entry, and a level-following pending bit from a sticky one.

// File: rtl/spi_lane_pkg.sv
package spi_lane_pkg;

    localparam logic [2:0] SEL_FMT    = 3'd0;
    localparam logic [2:0] SEL_TXDATA = 3'd1;
    localparam logic [2:0] SEL_RXDATA = 3'd2;
    localparam logic [2:0] SEL_TXMARK = 3'd3;
    localparam logic [2:0] SEL_RXMARK = 3'd4;
    localparam logic [2:0] SEL_IE     = 3'd5;
    localparam logic [2:0] SEL_IP     = 3'd6;

    typedef struct packed {
        logic [3:0] len;
        logic       txonly;
        logic       lsb_first;
        logic [1:0] lanes;
    } fmt_t;

    function automatic logic [2:0] lane_width(input logic [1:0] code);
        case (code)
            2'd1:    return 3'd2;
            2'd2:    return 3'd4;
            default: return 3'd1;
        endcase
    endfunction

    function automatic logic [3:0] lane_mask(input logic [2:0] w);
        case (w)
            3'd2:    return 4'b0011;
            3'd4:    return 4'b1111;
            default: return 4'b0001;
        endcase
    endfunction

endpackage

// File: rtl/spi_lane_fifo.sv
module spi_lane_fifo #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic [CNT_W-1:0] count
);
    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] mem;
        logic [PTR_W-1:0]            wptr;
        logic [PTR_W-1:0]            rptr;
        logic [CNT_W-1:0]            cnt;
    } fifo_t;

    fifo_t s_d, s_q;
    logic  take, give;

    function automatic logic [PTR_W-1:0] next_ptr(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        s_d  = s_q;
        take = push && (s_q.cnt != CNT_W'(DEPTH));
        give = pop && (s_q.cnt != '0);
        if (take) begin
            s_d.mem[s_q.wptr] = push_data;
            s_d.wptr          = next_ptr(s_q.wptr);
        end
        if (give) begin
            s_d.rptr = next_ptr(s_q.rptr);
        end
        case ({take, give})
            2'b10:   s_d.cnt = s_q.cnt + 1'b1;
            2'b01:   s_d.cnt = s_q.cnt - 1'b1;
            default: s_d.cnt = s_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign head  = s_q.mem[s_q.rptr];
    assign count = s_q.cnt;

endmodule

// File: rtl/spi_lane_serdes.sv
module spi_lane_serdes
    import spi_lane_pkg::*;
#(
    parameter int FRAME_W = 8,
    localparam int SH_W = ((FRAME_W + 3) / 4) * 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  fmt_t               fmt_i,
    input  logic               tx_valid,
    input  logic [FRAME_W-1:0] tx_data,
    output logic               tx_pop,
    output logic               rx_push,
    output logic [FRAME_W-1:0] rx_data,
    input  logic               launch,
    input  logic               sample,
    input  logic [3:0]         dq_in,
    output logic [3:0]         dq_out,
    output logic [3:0]         dq_oe,
    output logic               active
);
    typedef struct packed {
        logic            active;
        logic [1:0]      lanes;
        logic            lsb;
        logic            txonly;
        logic [3:0]      len;
        logic [3:0]      beats;
        logic [3:0]      beat;
        logic [SH_W-1:0] tx_sh;
        logic [SH_W-1:0] rx_sh;
    } ser_t;

    ser_t            s_d, s_q;
    logic [2:0]      nlw, lw, olw;
    logic [3:0]      nlen, lin;
    logic [SH_W-1:0] nrx, aligned;
    int              used;

    always_comb begin
        s_d     = s_q;
        tx_pop  = 1'b0;
        rx_push = 1'b0;
        rx_data = '0;
        nrx     = '0;
        aligned = '0;
        used    = 0;
        nlw     = lane_width(fmt_i.lanes);
        lw      = lane_width(s_q.lanes);
        nlen    = (fmt_i.len == 4'd0 || int'(fmt_i.len) > FRAME_W) ? 4'(FRAME_W) : fmt_i.len;
        lin     = (lw == 3'd1) ? {3'b000, dq_in[1]} : (dq_in & lane_mask(lw));
        if (!s_q.active) begin
            if (tx_valid) begin
                tx_pop     = 1'b1;
                s_d.active = 1'b1;
                s_d.lanes  = fmt_i.lanes;
                s_d.lsb    = fmt_i.lsb_first;
                s_d.txonly = fmt_i.txonly;
                s_d.len    = nlen;
                s_d.beats  = 4'((int'(nlen) + int'(nlw) - 1) / int'(nlw));
                s_d.beat   = '0;
                s_d.rx_sh  = '0;
                s_d.tx_sh  = fmt_i.lsb_first ? SH_W'(tx_data)
                                             : (SH_W'(tx_data) << (SH_W - int'(nlen)));
            end
        end else begin
            if (launch) begin
                s_d.tx_sh = s_q.lsb ? (s_q.tx_sh >> lw) : (s_q.tx_sh << lw);
            end
            if (sample) begin
                nrx = s_q.lsb ? ((s_q.rx_sh >> lw) | (SH_W'(lin) << (SH_W - int'(lw))))
                              : ((s_q.rx_sh << lw) | SH_W'(lin));
                s_d.rx_sh = nrx;
                s_d.beat  = s_q.beat + 4'd1;
                if (s_q.beat + 4'd1 == s_q.beats) begin
                    s_d.active = 1'b0;
                    rx_push    = !s_q.txonly;
                    used       = int'(s_q.beats) * int'(lw);
                    aligned    = s_q.lsb ? (nrx >> (SH_W - used)) : (nrx >> (used - int'(s_q.len)));
                    rx_data    = FRAME_W'(aligned & ~({SH_W{1'b1}} << s_q.len));
                end
            end
        end
    end

    always_comb begin
        dq_out = '0;
        dq_oe  = '0;
        olw    = lane_width(s_q.lanes);
        if (s_q.active) begin
            for (int j = 0; j < 4; j++) begin
                if (j < int'(olw)) begin
                    dq_out[j] = s_q.lsb ? s_q.tx_sh[j] : s_q.tx_sh[SH_W - int'(olw) + j];
                end
            end
            if (olw == 3'd1) dq_oe = 4'b0001;
            else             dq_oe = s_q.txonly ? lane_mask(olw) : 4'b0000;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign active = s_q.active;

endmodule

// File: rtl/spi_lane_shifter.sv
module spi_lane_shifter
    import spi_lane_pkg::*;
#(
    parameter int DEPTH   = 8,
    parameter int FRAME_W = 8,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  reg_sel,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        sck_launch,
    input  logic        sck_sample,
    input  logic [3:0]  dq_in,
    output logic [3:0]  dq_out,
    output logic [3:0]  dq_oe,
    output logic        frame_active,
    output logic        irq
);
    typedef struct packed {
        fmt_t             fmt;
        logic [CNT_W-1:0] tx_mark;
        logic [CNT_W-1:0] rx_mark;
        logic [1:0]       ie;
    } cfg_t;

    cfg_t               s_d, s_q;
    logic [CNT_W-1:0]   tx_count, rx_count;
    logic [FRAME_W-1:0] tx_head, rx_head, rx_word;
    logic               tx_write, rx_read, tx_pop, rx_push, tx_full, rx_empty;
    logic [1:0]         ip;
    logic               wdata_unused;

    assign wdata_unused = ^{reg_wdata[31:20], reg_wdata[15:8]};
    assign tx_write     = reg_wr && (reg_sel == SEL_TXDATA);
    assign rx_read      = reg_rd && (reg_sel == SEL_RXDATA);
    assign tx_full      = (tx_count == CNT_W'(DEPTH));
    assign rx_empty     = (rx_count == '0);
    assign ip           = {rx_count > s_q.rx_mark, tx_count < s_q.tx_mark};
    assign irq          = |(ip & s_q.ie);

    spi_lane_fifo #(.DEPTH(DEPTH), .WIDTH(FRAME_W)) u_txq (
        .clk(clk), .rst_n(rst_n), .push(tx_write), .push_data(reg_wdata[FRAME_W-1:0]),
        .pop(tx_pop), .head(tx_head), .count(tx_count)
    );

    spi_lane_fifo #(.DEPTH(DEPTH), .WIDTH(FRAME_W)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .push_data(rx_word),
        .pop(rx_read), .head(rx_head), .count(rx_count)
    );

    spi_lane_serdes #(.FRAME_W(FRAME_W)) u_serdes (
        .clk(clk), .rst_n(rst_n), .fmt_i(s_q.fmt),
        .tx_valid(tx_count != '0), .tx_data(tx_head), .tx_pop(tx_pop),
        .rx_push(rx_push), .rx_data(rx_word),
        .launch(sck_launch), .sample(sck_sample), .dq_in(dq_in),
        .dq_out(dq_out), .dq_oe(dq_oe), .active(frame_active)
    );

    always_comb begin
        s_d = s_q;
        if (reg_wr) begin
            case (reg_sel)
                SEL_FMT: begin
                    s_d.fmt.len       = reg_wdata[19:16];
                    s_d.fmt.txonly    = reg_wdata[3];
                    s_d.fmt.lsb_first = reg_wdata[2];
                    s_d.fmt.lanes     = reg_wdata[1:0];
                end
                SEL_TXMARK: s_d.tx_mark = reg_wdata[CNT_W-1:0];
                SEL_RXMARK: s_d.rx_mark = reg_wdata[CNT_W-1:0];
                SEL_IE:     s_d.ie      = reg_wdata[1:0];
                default:    ;
            endcase
        end
    end

    always_comb begin
        case (reg_sel)
            SEL_FMT:    reg_rdata = {12'b0, s_q.fmt.len, 12'b0, s_q.fmt.txonly,
                                     s_q.fmt.lsb_first, s_q.fmt.lanes};
            SEL_TXDATA: reg_rdata = {tx_full, 31'b0};
            SEL_RXDATA: reg_rdata = rx_empty ? 32'h8000_0000 : 32'(rx_head);
            SEL_TXMARK: reg_rdata = 32'(s_q.tx_mark);
            SEL_RXMARK: reg_rdata = 32'(s_q.rx_mark);
            SEL_IE:     reg_rdata = {30'b0, s_q.ie};
            SEL_IP:     reg_rdata = {30'b0, ip};
            default:    reg_rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q         <= '0;
            s_q.fmt.len <= 4'(FRAME_W);
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/spi_lane_shifter_chk.sv
module spi_lane_shifter_chk #(
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] tx_count,
    input logic [CNT_W-1:0] rx_count,
    input logic             tx_write,
    input logic             tx_pop,
    input logic             rx_read,
    input logic             rx_push,
    input logic             frame_active,
    input logic [3:0]       dq_oe,
    input logic [1:0]       ie,
    input logic             irq
);
    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(tx_count) <= DEPTH) && (int'(rx_count) <= DEPTH));

    assert_full_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(tx_count) == DEPTH && tx_write && !tx_pop) |=> $stable(tx_count));

    assert_empty_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_count == '0 && rx_read && !rx_push) |=> (rx_count == '0));

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_active |-> (dq_oe == 4'b0000));

    assert_load_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> !frame_active);

    assert_load_starts_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |=> frame_active);

    assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ie == 2'b00) |-> !irq);

endmodule

bind spi_lane_shifter spi_lane_shifter_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .tx_count(tx_count), .rx_count(rx_count),
    .tx_write(tx_write), .tx_pop(tx_pop), .rx_read(rx_read), .rx_push(rx_push),
    .frame_active(frame_active), .dq_oe(dq_oe), .ie(s_q.ie), .irq(irq)
);

// File: tb/spi_lane_shifter_tb.sv
module spi_lane_shifter_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  reg_sel = '0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        sck_launch = 1'b0, sck_sample = 1'b0;
    logic [3:0]  dq_in = '0;
    logic [3:0]  dq_out, dq_oe;
    logic        frame_active, irq;

    int total = 0;
    int bad   = 0;
    bit ended = 0;

    always #4 clk = ~clk;

    spi_lane_shifter u_dut (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sck_launch(sck_launch),
        .sck_sample(sck_sample), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
        .frame_active(frame_active), .irq(irq)
    );

    // {lanes[2], lsb, txonly, len[4], tx[8], rx[8]}
    localparam logic [23:0] VEC [13] = '{
        {2'd0, 1'b0, 1'b0, 4'd8,  8'hA5, 8'h3C},
        {2'd0, 1'b1, 1'b0, 4'd8,  8'h96, 8'hC1},
        {2'd0, 1'b0, 1'b0, 4'd5,  8'h1B, 8'h15},
        {2'd1, 1'b0, 1'b1, 4'd8,  8'hD2, 8'h00},
        {2'd1, 1'b1, 1'b0, 4'd8,  8'h00, 8'h6E},
        {2'd2, 1'b0, 1'b0, 4'd8,  8'h00, 8'hB7},
        {2'd2, 1'b1, 1'b1, 4'd8,  8'h4D, 8'h00},
        {2'd1, 1'b0, 1'b0, 4'd3,  8'h00, 8'h05},
        {2'd2, 1'b1, 1'b1, 4'd6,  8'h2B, 8'h00},
        {2'd3, 1'b0, 1'b0, 4'd8,  8'h71, 8'h9E},
        {2'd0, 1'b0, 1'b0, 4'd0,  8'hE4, 8'h5A},
        {2'd2, 1'b0, 1'b1, 4'd7,  8'h5C, 8'h00},
        {2'd0, 1'b1, 1'b0, 4'd12, 8'h3A, 8'hA7}
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [2:0] sel, input logic [31:0] d);
        @(negedge clk); reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] sel, output logic [31:0] d);
        @(negedge clk); reg_sel = sel; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    task automatic beat(input logic [3:0] din, output logic [3:0] o, output logic [3:0] e, output logic act);
        @(negedge clk); o = dq_out; e = dq_oe; dq_in = din; sck_sample = 1'b1;
        @(negedge clk); act = frame_active; sck_sample = 1'b0; sck_launch = 1'b1;
        @(negedge clk); sck_launch = 1'b0;
    endtask

    function automatic int lanes_of(input int p);
        return (p == 1) ? 2 : ((p == 2) ? 4 : 1);
    endfunction

    function automatic int eff_len(input int l);
        return (l == 0 || l > 8) ? 8 : l;
    endfunction

    function automatic int bit_at(input int k, input int j, input int w, input int l, input bit lsb);
        int pos;
        if (lsb) begin
            pos = k * w + j;
            return (pos < l) ? pos : -1;
        end
        pos = k * w + (w - 1 - j);
        return (l - 1 - pos >= 0) ? (l - 1 - pos) : -1;
    endfunction

    task automatic run_frame(input int p, input bit lsb, input bit txo, input int len,
                             input logic [7:0] tx, input logic [7:0] rx);
        int w, l, n, bad_tx, bad_oe, bad_act, idx;
        logic [3:0] din, o, e, exp_oe;
        logic act;
        w = lanes_of(p); l = eff_len(len); n = (l + w - 1) / w;
        bad_tx = 0; bad_oe = 0; bad_act = 0;
        exp_oe = (w == 1) ? 4'b0001 : (txo ? ((w == 2) ? 4'b0011 : 4'b1111) : 4'b0000);
        for (int k = 0; k < n; k++) begin
            din = '0;
            for (int j = 0; j < w; j++) begin
                idx = bit_at(k, j, w, l, lsb);
                if (idx >= 0) begin
                    if (w == 1) din[1] = rx[idx];
                    else        din[j] = rx[idx];
                end
            end
            beat(din, o, e, act);
            if (e != exp_oe) bad_oe++;
            if (exp_oe != 4'b0000) begin
                for (int j = 0; j < w; j++) begin
                    idx = bit_at(k, j, w, l, lsb);
                    if (idx >= 0 && o[j] !== tx[idx]) bad_tx++;
                end
            end
            if (act !== (k != n - 1)) bad_act++;
        end
        check(bad_oe == 0, "R2 lane enables", 32'(bad_oe), 32'd0);
        if (exp_oe != 4'b0000) check(bad_tx == 0, "R3 transmit bits and order", 32'(bad_tx), 32'd0);
        check(bad_act == 0, "R4 beats per frame", 32'(bad_act), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!ended) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic [7:0]  mask;
        int p, len;
        bit lsb, txo;
        logic [7:0] tx, rx;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        check(frame_active == 1'b0 && dq_oe == 4'b0, "R1 idle outputs", {27'b0, frame_active, dq_oe}, 32'd0);
        check(irq == 1'b0, "R1 irq", 32'(irq), 32'd0);
        reg_read(3'd0, rd); check(rd == 32'h0008_0000, "R1 format", rd, 32'h0008_0000);
        reg_read(3'd6, rd); check(rd == 32'd0, "R1 pending", rd, 32'd0);
        reg_read(3'd1, rd); check(rd == 32'd0, "R6 not full at reset", rd, 32'd0);
        reg_read(3'd2, rd); check(rd == 32'h8000_0000, "R7 empty at reset", rd, 32'h8000_0000);

        // Table of frames: R2 R3 R4 R5
        for (int v = 0; v < 13; v++) begin
            {p, lsb, txo, len, tx, rx} = {30'd0, VEC[v][23:22], VEC[v][21], VEC[v][20],
                                          28'd0, VEC[v][19:16], VEC[v][15:8], VEC[v][7:0]};
            reg_write(3'd0, {12'b0, 4'(len), 12'b0, txo, lsb, 2'(p)});
            reg_write(3'd1, {24'b0, tx});
            run_frame(p, lsb, txo, len, tx, rx);
            reg_read(3'd2, rd);
            mask = 8'((9'd1 << eff_len(len)) - 9'd1);
            if (txo) check(rd == 32'h8000_0000, "R5 transmit-only frame not received", rd, 32'h8000_0000);
            else     check(rd == {24'b0, rx & mask}, "R3 R4 received frame", rd, {24'b0, rx & mask});
        end

        // R6 R10: overfill the transmit queue
        reg_write(3'd0, {12'b0, 4'd8, 12'b0, 1'b1, 1'b0, 2'd2});
        for (int i = 0; i < 10; i++) reg_write(3'd1, 32'h10 + 32'(i));
        reg_read(3'd1, rd); check(rd == 32'h8000_0000, "R6 full flag", rd, 32'h8000_0000);
        reg_write(3'd3, 32'd8);
        reg_read(3'd6, rd); check(rd == 32'd0, "R8 tx mark equal count", rd, 32'd0);
        reg_write(3'd3, 32'd9);
        reg_read(3'd6, rd); check(rd == 32'd1, "R8 tx mark above count", rd, 32'd1);
        reg_write(3'd5, 32'd1);
        check(irq == 1'b1, "R9 irq enabled tx", 32'(irq), 32'd1);
        reg_write(3'd5, 32'd0);
        check(irq == 1'b0, "R9 irq masked", 32'(irq), 32'd0);
        reg_write(3'd3, 32'd0);
        for (int i = 0; i < 9; i++) begin
            run_frame(2, 1'b0, 1'b1, 8, 8'h10 + 8'(i), 8'h00);
            if (i == 0) begin
                reg_read(3'd1, rd); check(rd == 32'd0, "R6 full cleared after drain", rd, 32'd0);
            end
        end
        repeat (3) @(negedge clk);
        check(frame_active == 1'b0, "R6 dropped write never sent", 32'(frame_active), 32'd0);

        // R7 R8 R9: receive watermark and empty reads
        reg_write(3'd0, {12'b0, 4'd8, 16'b0});
        reg_write(3'd4, 32'd1);
        reg_write(3'd1, 32'h00); run_frame(0, 1'b0, 1'b0, 8, 8'h00, 8'h11);
        reg_read(3'd6, rd); check(rd == 32'd0, "R8 rx count equal mark", rd, 32'd0);
        reg_write(3'd1, 32'h00); run_frame(0, 1'b0, 1'b0, 8, 8'h00, 8'h22);
        reg_read(3'd6, rd); check(rd == 32'd2, "R8 rx count above mark", rd, 32'd2);
        reg_write(3'd5, 32'd2);
        check(irq == 1'b1, "R9 irq enabled rx", 32'(irq), 32'd1);
        reg_write(3'd5, 32'd1);
        check(irq == 1'b0, "R9 irq other enable", 32'(irq), 32'd0);
        reg_read(3'd2, rd); check(rd == 32'h11, "R7 oldest first", rd, 32'h11);
        reg_read(3'd6, rd); check(rd == 32'd0, "R8 pending follows count", rd, 32'd0);
        reg_read(3'd2, rd); check(rd == 32'h22, "R7 second entry", rd, 32'h22);
        reg_read(3'd2, rd); check(rd == 32'h8000_0000, "R7 empty read", rd, 32'h8000_0000);
        reg_read(3'd2, rd); check(rd == 32'h8000_0000, "R7 repeated empty read", rd, 32'h8000_0000);
        reg_write(3'd1, 32'h00); run_frame(0, 1'b0, 1'b0, 8, 8'h00, 8'h33);
        reg_read(3'd2, rd); check(rd == 32'h33, "R7 pointers intact after empty reads", rd, 32'h33);

        ended = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule